// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Receiver with Run-Length Expansion

This block is the host half of a byte-wide reverse channel on an IEEE 1284 parallel port running in the extended-capability mode. On a read request it first checks the bus direction. If the port still faces forward, it turns the bus around: it switches the data pins to input and walks the control lines through the reverse-entry handshake. It then accepts bytes that the peripheral strobes with nAck. The level of Busy at the falling edge of nAck tells data from command.

Command bytes are decoded in hardware. A command with the top bit set is a channel address and is dropped. Any other command is a run length. The data byte that follows a run-length command is delivered once and then repeated that many more times. The repeats are issued from the block's own register, one per clock, and the peripheral is not involved.

Delivered bytes leave on a valid/ready stream and are counted against the requested length. A run that does not fit in one request is held over for the next request. A separate request turns the bus back to forward and clears any held-over run. All protocol timeouts are counted in ticks of a prescaled clock.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset, the data direction output is 0 (forward), and nAutoFd, nInit, nStrobe and nSelectIn are all high. outValid and done are 0.
- R2: A read request while the port faces forward sets dataDirIn to 1 and drives nAutoFd low in the same cycle. After SETUP_TICKS ticks, nInit goes low while nStrobe and nSelectIn stay high. If PError does not go low within RESP_TICKS ticks, the request ends with done, doneErr=1 and xferCount=0.
- R3: A byte whose nAck falling edge sees Busy high is delivered on the stream. A byte whose falling edge sees Busy low is a command and is never delivered.
- R4: A command byte with bit 7 = 1 is discarded and changes no run state. A command byte with bit 7 = 0 loads bits 6:0 as a run count.
- R5: The first data byte after a run-count command of N is delivered once and then N more times, N = 0 giving a single copy.
- R6: A run is cut at the request length. The unused count is kept and is delivered first on the next read, one byte per cycle while outReady is high, with no nAutoFd handshake until the run or the request is used up.
- R7: After each received byte the block raises nAutoFd, waits up to RESP_TICKS ticks for nAck high and then lowers nAutoFd. If nAck stays low, the request ends with doneErr=1 and nAutoFd is returned low.
- R8: If nAck does not fall within IDLE_TICKS ticks, the request ends with doneErr=0 and xferCount equal to the bytes delivered so far.
- R9: A forward request while the port faces reverse raises nInit and waits up to RESP_TICKS ticks for PError high. It then raises nAutoFd and sets dataDirIn to 0. It also clears any held-over run.
- R10: While outValid is high and outReady is low, outValid stays high and outData stays unchanged.
- R11: done is a one-cycle pulse. When a read ends, xferCount is the number of stream transfers in that request and never exceeds reqLen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startRead | input | 1 | Pulse: start a read of reqLen bytes (taken when idle) |
| reqLen | input | LEN_W | Requested byte count, sampled with startRead |
| startFwd | input | 1 | Pulse: turn the bus back to forward (taken when idle) |
| dataIn | input | 8 | Parallel data bus from peripheral |
| nAck | input | 1 | Peripheral strobe, active low |
| busyIn | input | 1 | Busy line: high = data byte, low = command byte |
| pError | input | 1 | PError line, used as turnaround acknowledge |
| nAutoFd | output | 1 | Host acknowledge line |
| nInit | output | 1 | Host reverse-request line |
| nStrobe | output | 1 | Host strobe, held high |
| nSelectIn | output | 1 | Host select line, held high |
| dataDirIn | output | 1 | 1 = data pins are inputs (reverse) |
| outValid | output | 1 | Stream byte valid |
| outReady | input | 1 | Stream consumer ready |
| outData | output | 8 | Stream byte |
| done | output | 1 | One-cycle pulse at the end of a request |
| doneErr | output | 1 | Timeout status of the last request |
| xferCount | output | LEN_W | Bytes delivered in the last request |

## Verification
The bench targets the points where run state and request length meet. A run that crosses request boundaries exposes a design that drops or restarts the held-over count: the second read would then return the wrong number of copies or stall waiting on nAck. A channel-address command whose low bits look like a run count is followed by a one-byte read and then a second one-byte read. A design that armed a run from it would return a stale copy on the second read instead of the fresh byte. The bench also covers missing PError and nAck responses, to tell a quiet end from an error end, and a forward turnaround with a run pending. A design that kept the run across the turnaround would replay old bytes.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;

  typedef struct packed {
    logic clrTick;    // restart the tick window
    logic loadReq;    // accept a new request length
    logic latchRx;    // capture the bus byte
    logic takeByte;   // one stream transfer completed
    logic takeCopy;   // that transfer was a run copy
    logic armRun;     // load run count from the bus
    logic setRepeat;  // captured byte becomes the repeat byte
    logic dropRun;    // forget any run state
  } dpCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REV_SETUP, ST_REV_PE, ST_CHECK, ST_EMIT_RUN,
    ST_WAIT_STB, ST_EMIT_DATA, ST_ACK, ST_FWD_PE
  } rxState_t;

endpackage

// File: rtl/ecp_rev_dp.sv
module ecp_rev_dp
  import ecp_rev_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int TICK_DIV = 50,
  parameter int TICK_W   = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       dataIn,
  input  logic             useRepeat,
  output logic [TICK_W-1:0] tickCnt,
  output logic             remainZero,
  output logic             remainLast,
  output logic             runReady,
  output logic             runLast,
  output logic             runArmed,
  output logic [7:0]       outData,
  output logic [LEN_W-1:0] xferCount
);
  localparam int DIV_W = $clog2(TICK_DIV + 1);
  localparam logic [DIV_W-1:0]  DIV_MAX  = DIV_W'(TICK_DIV - 1);
  localparam logic [TICK_W-1:0] TICK_MAX = '1;

  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic [LEN_W-1:0] remain;
  logic [6:0]       runLeft;
  logic [7:0]       rxByte;
  logic [7:0]       repeatByte;

  assign tick = (divCnt == DIV_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) tickCnt <= '0;
    else if (cmd.clrTick) tickCnt <= '0;
    else if (tick && tickCnt != TICK_MAX) tickCnt <= tickCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remain    <= '0;
      xferCount <= '0;
    end else if (cmd.loadReq) begin
      remain    <= reqLen;
      xferCount <= '0;
    end else if (cmd.takeByte) begin
      remain    <= remain - 1'b1;
      xferCount <= xferCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLeft    <= '0;
      runArmed   <= 1'b0;
      rxByte     <= '0;
      repeatByte <= '0;
    end else begin
      if (cmd.latchRx) rxByte <= dataIn;
      if (cmd.dropRun) begin
        runLeft  <= '0;
        runArmed <= 1'b0;
      end else if (cmd.armRun) begin
        runLeft  <= dataIn[6:0];
        runArmed <= 1'b1;
      end else if (cmd.setRepeat) begin
        repeatByte <= rxByte;
        runArmed   <= 1'b0;
      end else if (cmd.takeCopy) begin
        runLeft <= runLeft - 1'b1;
      end
    end
  end

  assign remainZero = (remain == '0);
  assign remainLast = (remain == LEN_W'(1));
  assign runReady   = (runLeft != '0) && !runArmed;
  assign runLast    = (runLeft == 7'd1);
  assign outData    = useRepeat ? repeatByte : rxByte;

endmodule

// File: rtl/ecp_rev_ctrl.sv
module ecp_rev_ctrl
  import ecp_rev_pkg::*;
#(
  parameter int TICK_W      = 11,
  parameter int SETUP_TICKS = 1,
  parameter int RESP_TICKS  = 6,
  parameter int IDLE_TICKS  = 2000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startRead,
  input  logic        startFwd,
  input  logic        nAck,
  input  logic        busyIn,
  input  logic        pError,
  input  logic        dataBit7,
  input  logic        outReady,
  input  logic [TICK_W-1:0] tickCnt,
  input  logic        remainZero,
  input  logic        remainLast,
  input  logic        runReady,
  input  logic        runLast,
  input  logic        runArmed,
  output dpCmd_t      cmd,
  output logic        nAutoFd,
  output logic        nInit,
  output logic        dirIn,
  output logic        outValid,
  output logic        useRepeat,
  output logic        done,
  output logic        doneErr
);
  localparam logic [TICK_W-1:0] SETUP_LIM = TICK_W'(SETUP_TICKS);
  localparam logic [TICK_W-1:0] RESP_LIM  = TICK_W'(RESP_TICKS);
  localparam logic [TICK_W-1:0] IDLE_LIM  = TICK_W'(IDLE_TICKS);

  rxState_t state, stateN;
  logic afN, niN, dirN, doneN, errN;

  always_comb begin
    cmd    = '0;
    stateN = state;
    afN    = nAutoFd;
    niN    = nInit;
    dirN   = dirIn;
    doneN  = 1'b0;
    errN   = doneErr;
    case (state)
      ST_IDLE: begin
        if (startRead) begin
          cmd.loadReq = 1'b1;
          cmd.clrTick = 1'b1;
          if (!dirIn) begin
            dirN   = 1'b1;
            afN    = 1'b0;
            stateN = ST_REV_SETUP;
          end else stateN = ST_CHECK;
        end else if (startFwd) begin
          cmd.loadReq = 1'b1;
          cmd.dropRun = 1'b1;
          cmd.clrTick = 1'b1;
          if (dirIn) begin
            niN    = 1'b1;
            stateN = ST_FWD_PE;
          end else begin
            doneN = 1'b1;
            errN  = 1'b0;
          end
        end
      end
      ST_REV_SETUP: if (tickCnt >= SETUP_LIM) begin
        niN         = 1'b0;
        cmd.clrTick = 1'b1;
        stateN      = ST_REV_PE;
      end
      ST_REV_PE: begin
        if (!pError) stateN = ST_CHECK;
        else if (tickCnt >= RESP_LIM) begin
          stateN = ST_IDLE;
          doneN  = 1'b1;
          errN   = 1'b1;
        end
      end
      ST_CHECK: begin
        if (remainZero) begin
          stateN = ST_IDLE;
          doneN  = 1'b1;
          errN   = 1'b0;
        end else if (runReady) stateN = ST_EMIT_RUN;
        else begin
          cmd.clrTick = 1'b1;
          stateN      = ST_WAIT_STB;
        end
      end
      ST_EMIT_RUN: if (outReady) begin
        cmd.takeByte = 1'b1;
        cmd.takeCopy = 1'b1;
        if (remainLast || runLast) stateN = ST_CHECK;
      end
      ST_WAIT_STB: begin
        if (!nAck) begin
          cmd.latchRx = 1'b1;
          if (busyIn) stateN = ST_EMIT_DATA;
          else begin
            cmd.armRun  = !dataBit7;
            cmd.clrTick = 1'b1;
            afN         = 1'b1;
            stateN      = ST_ACK;
          end
        end else if (tickCnt >= IDLE_LIM) begin
          stateN = ST_IDLE;
          doneN  = 1'b1;
          errN   = 1'b0;
        end
      end
      ST_EMIT_DATA: if (outReady) begin
        cmd.takeByte  = 1'b1;
        cmd.setRepeat = runArmed;
        cmd.clrTick   = 1'b1;
        afN           = 1'b1;
        stateN        = ST_ACK;
      end
      ST_ACK: begin
        if (nAck) begin
          afN    = 1'b0;
          stateN = ST_CHECK;
        end else if (tickCnt >= RESP_LIM) begin
          afN    = 1'b0;
          stateN = ST_IDLE;
          doneN  = 1'b1;
          errN   = 1'b1;
        end
      end
      ST_FWD_PE: if (pError || tickCnt >= RESP_LIM) begin
        afN    = 1'b1;
        dirN   = 1'b0;
        stateN = ST_IDLE;
        doneN  = 1'b1;
        errN   = !pError;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      nAutoFd <= 1'b1;
      nInit   <= 1'b1;
      dirIn   <= 1'b0;
      done    <= 1'b0;
      doneErr <= 1'b0;
    end else begin
      state   <= stateN;
      nAutoFd <= afN;
      nInit   <= niN;
      dirIn   <= dirN;
      done    <= doneN;
      doneErr <= errN;
    end
  end

  assign outValid  = (state == ST_EMIT_RUN) || (state == ST_EMIT_DATA);
  assign useRepeat = (state == ST_EMIT_RUN);

endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecp_rev_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int TICK_DIV    = 50,
  parameter int SETUP_TICKS = 1,
  parameter int RESP_TICKS  = 6,
  parameter int IDLE_TICKS  = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startRead,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             startFwd,
  input  logic [7:0]       dataIn,
  input  logic             nAck,
  input  logic             busyIn,
  input  logic             pError,
  output logic             nAutoFd,
  output logic             nInit,
  output logic             nStrobe,
  output logic             nSelectIn,
  output logic             dataDirIn,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             done,
  output logic             doneErr,
  output logic [LEN_W-1:0] xferCount
);
  localparam int MAX_TICKS = (IDLE_TICKS > RESP_TICKS) ?
                             ((IDLE_TICKS > SETUP_TICKS) ? IDLE_TICKS : SETUP_TICKS) :
                             ((RESP_TICKS > SETUP_TICKS) ? RESP_TICKS : SETUP_TICKS);
  localparam int TICK_W = $clog2(MAX_TICKS + 2);

  dpCmd_t            cmd;
  logic [TICK_W-1:0] tickCnt;
  logic remainZero, remainLast, runReady, runLast, runArmed, useRepeat;

  assign nStrobe   = 1'b1;
  assign nSelectIn = 1'b1;

  ecp_rev_ctrl #(
    .TICK_W(TICK_W), .SETUP_TICKS(SETUP_TICKS),
    .RESP_TICKS(RESP_TICKS), .IDLE_TICKS(IDLE_TICKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startRead(startRead), .startFwd(startFwd),
    .nAck(nAck), .busyIn(busyIn), .pError(pError), .dataBit7(dataIn[7]),
    .outReady(outReady), .tickCnt(tickCnt), .remainZero(remainZero),
    .remainLast(remainLast), .runReady(runReady), .runLast(runLast),
    .runArmed(runArmed), .cmd(cmd), .nAutoFd(nAutoFd), .nInit(nInit),
    .dirIn(dataDirIn), .outValid(outValid), .useRepeat(useRepeat),
    .done(done), .doneErr(doneErr)
  );

  ecp_rev_dp #(
    .LEN_W(LEN_W), .TICK_DIV(TICK_DIV), .TICK_W(TICK_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reqLen(reqLen), .dataIn(dataIn),
    .useRepeat(useRepeat), .tickCnt(tickCnt), .remainZero(remainZero),
    .remainLast(remainLast), .runReady(runReady), .runLast(runLast),
    .runArmed(runArmed), .outData(outData), .xferCount(xferCount)
  );

endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       nAutoFd,
  input logic       nInit,
  input logic       dataDirIn,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       done
);
  AST_FWD_PINS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !dataDirIn |-> nAutoFd && nInit);                                   // R1

  AST_REV_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataDirIn) |-> !nAutoFd && nInit);                            // R2

  AST_NO_OUTPUT_IN_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (dataDirIn && nAutoFd) |-> !outValid);                              // R7

  AST_FWD_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataDirIn) |-> nAutoFd && nInit);                             // R9

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outData));          // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                                    // R11
endmodule

bind ecp_rev_rx ecp_rev_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .nAutoFd(nAutoFd), .nInit(nInit),
  .dataDirIn(dataDirIn), .outValid(outValid), .outReady(outReady),
  .outData(outData), .done(done)
);

// File: tb/ecp_rev_rx_tb.sv
module ecp_rev_rx_tb;
  localparam int LEN_W = 16;

  logic clk = 0, rstN = 0;
  logic startRead = 0, startFwd = 0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [7:0] dataBus = 8'h00;
  logic nAckLine = 1, busyLine = 0, pErrLine = 1;
  logic nAutoFd, nInit, nStrobe, nSelectIn, dataDirIn;
  logic outValid, outReady = 1;
  logic [7:0] outData;
  logic done, doneErr;
  logic [LEN_W-1:0] xferCount;

  int checks = 0, fails = 0;
  bit randReady = 0;
  logic [7:0] rxQ[$];
  int ackRises = 0;
  bit prevStall = 0;
  logic [7:0] prevData = 0;

  always #10 clk = ~clk;

  ecp_rev_rx #(.LEN_W(LEN_W), .TICK_DIV(4), .SETUP_TICKS(1),
               .RESP_TICKS(6), .IDLE_TICKS(40)) u_dut (
    .clk(clk), .rstN(rstN), .startRead(startRead), .reqLen(reqLen),
    .startFwd(startFwd), .dataIn(dataBus), .nAck(nAckLine), .busyIn(busyLine),
    .pError(pErrLine), .nAutoFd(nAutoFd), .nInit(nInit), .nStrobe(nStrobe),
    .nSelectIn(nSelectIn), .dataDirIn(dataDirIn), .outValid(outValid),
    .outReady(outReady), .outData(outData), .done(done), .doneErr(doneErr),
    .xferCount(xferCount)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge nAutoFd) ackRises++;

  // stream consumer: random ready, hold check (R10)
  always @(negedge clk) begin
    if (rstN && prevStall)
      check("R10 hold", outValid && outData == prevData, {outValid, outData}, {1'b1, prevData});
    outReady = randReady ? ($urandom_range(3) != 0) : 1'b1;
    #1;
    if (outValid && outReady) rxQ.push_back(outData);
    prevStall = outValid && !outReady;
    prevData  = outData;
  end

  task automatic send_item(input bit isData, input logic [7:0] val);
    @(negedge clk); dataBus = val; busyLine = isData;
    @(negedge clk); nAckLine = 0;
    wait (nAutoFd == 1'b1);
    @(negedge clk); nAckLine = 1;
    wait (nAutoFd == 1'b0);
    @(negedge clk);
  endtask

  task automatic rev_turn();
    wait (nInit == 1'b0);
    #2;
    check("R2 reverse pins", dataDirIn && !nAutoFd && nStrobe && nSelectIn,
          {dataDirIn, nAutoFd, nStrobe, nSelectIn}, 4'b1011);
    repeat (2) @(negedge clk);
    pErrLine = 0;
  endtask

  task automatic fwd_turn();
    wait (nInit == 1'b1);
    repeat (2) @(negedge clk);
    pErrLine = 1;
  endtask

  task automatic do_read(input int len, input bit chkEntry, output int cnt, output bit err);
    @(negedge clk); startRead = 1; reqLen = LEN_W'(len);
    @(negedge clk); startRead = 0;
    if (chkEntry)
      check("R2 entry", dataDirIn && !nAutoFd && nInit, {dataDirIn, nAutoFd, nInit}, 3'b101);
    while (!done) @(negedge clk);
    cnt = int'(xferCount); err = doneErr;
    @(negedge clk);
    check("R11 done pulse", !done, done, 0);
  endtask

  task automatic do_fwd(output bit err);
    @(negedge clk); startFwd = 1;
    @(negedge clk); startFwd = 0;
    while (!done) @(negedge clk);
    err = doneErr;
    @(negedge clk);
  endtask

  task automatic cmp_q(input string req, input logic [7:0] exp[$]);
    bit ok = (rxQ.size() == exp.size());
    if (ok) foreach (exp[i]) if (rxQ[i] !== exp[i]) ok = 0;
    check(req, ok, rxQ.size() > 0 ? rxQ[rxQ.size()-1] : 0, exp.size() > 0 ? exp[exp.size()-1] : 0);
    if (!ok) $display("  size actual=%0d expected=%0d", rxQ.size(), exp.size());
  endtask

  // expected expansion of an item list (R3-R5)
  function automatic void expand(input bit kinds[$], input logic [7:0] vals[$], ref logic [7:0] exp[$]);
    int runLen = 0; bit armed = 0;
    exp.delete();
    foreach (kinds[i]) begin
      if (kinds[i]) begin
        exp.push_back(vals[i]);
        if (armed) for (int k = 0; k < runLen; k++) exp.push_back(vals[i]);
        armed = 0;
      end else if (!vals[i][7]) begin
        runLen = vals[i][6:0]; armed = 1;
      end
    end
  endfunction

  initial begin
    int cnt; bit err; int acks0;
    logic [7:0] exp[$];
    bit kinds[$]; logic [7:0] vals[$];
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset pins", !dataDirIn && nAutoFd && nInit && nStrobe && nSelectIn,
          {dataDirIn, nAutoFd, nInit, nStrobe, nSelectIn}, 5'b01111);
    check("R1 reset stream", !outValid && !done, {outValid, done}, 0);

    // R2 turnaround timeout: PError never falls
    do_read(3, 1, cnt, err);
    check("R2 turn timeout err", err == 1, err, 1);
    check("R2 turn timeout count", cnt == 0, cnt, 0);
    do_fwd(err);
    check("R9 fwd pins", !dataDirIn && nAutoFd && nInit, {dataDirIn, nAutoFd, nInit}, 3'b011);

    // R3 plain data
    rxQ.delete();
    fork
      begin rev_turn(); send_item(1, 8'hA1); send_item(1, 8'hB2); send_item(1, 8'hC3); end
      do_read(3, 1, cnt, err);
    join
    exp = '{8'hA1, 8'hB2, 8'hC3};
    cmp_q("R3 data bytes", exp);
    check("R11 count", cnt == 3 && !err, cnt, 3);

    // R4/R5 channel + run
    rxQ.delete();
    fork
      begin send_item(0, 8'h85); send_item(0, 8'h04); send_item(1, 8'h5A);
            send_item(1, 8'h11); send_item(1, 8'h22); end
      do_read(7, 0, cnt, err);
    join
    exp = '{8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h5A, 8'h11, 8'h22};
    cmp_q("R5 run expansion", exp);

    // R4 address command must not arm a run
    rxQ.delete();
    fork send_item(0, 8'h83); send_item(1, 8'h10); do_read(1, 0, cnt, err); join
    fork send_item(1, 8'h20); do_read(1, 0, cnt, err); join
    exp = '{8'h10, 8'h20};
    cmp_q("R4 address discarded", exp);

    // R6 run spanning requests
    rxQ.delete();
    fork begin send_item(0, 8'h0A); send_item(1, 8'h77); end do_read(4, 0, cnt, err); join
    check("R6 first chunk count", cnt == 4, cnt, 4);
    acks0 = ackRises;
    do_read(5, 0, cnt, err);
    check("R6 no handshake in run", ackRises == acks0, ackRises, acks0);
    check("R6 second chunk count", cnt == 5, cnt, 5);
    fork send_item(1, 8'h33); do_read(3, 0, cnt, err); join
    exp = '{};
    for (int i = 0; i < 11; i++) exp.push_back(8'h77);
    exp.push_back(8'h33);
    cmp_q("R6 chunked run", exp);

    // R8 idle timeout, quiet end
    rxQ.delete();
    fork begin send_item(1, 8'h01); send_item(1, 8'h02); end do_read(4, 0, cnt, err); join
    check("R8 idle count", cnt == 2, cnt, 2);
    check("R8 idle no error", err == 0, err, 0);

    // R7 ack timeout
    fork
      begin @(negedge clk); dataBus = 8'hAB; busyLine = 1; @(negedge clk); nAckLine = 0; end
      do_read(2, 0, cnt, err);
    join
    check("R7 ack timeout err", err == 1, err, 1);
    check("R7 ack timeout count", cnt == 1, cnt, 1);
    check("R7 nAutoFd low", !nAutoFd, nAutoFd, 0);
    nAckLine = 1;
    repeat (2) @(negedge clk);

    // R9 forward clears pending run
    rxQ.delete();
    fork begin send_item(0, 8'h05); send_item(1, 8'h44); end do_read(1, 0, cnt, err); join
    fork fwd_turn(); do_fwd(err); join
    check("R9 fwd ok", err == 0 && !dataDirIn && nAutoFd && nInit, {err, dataDirIn, nAutoFd, nInit}, 4'b0011);
    fork begin rev_turn(); send_item(1, 8'h99); end do_read(1, 1, cnt, err); join
    exp = '{8'h44, 8'h99};
    cmp_q("R9 run cleared", exp);

    // random rounds with random ready
    randReady = 1;
    for (int r = 0; r < 6; r++) begin
      int n = 3 + int'($urandom_range(5));
      kinds.delete(); vals.delete();
      for (int i = 0; i < n; i++) begin
        bit isD = (i == n-1) || ($urandom_range(9) > 2);
        kinds.push_back(isD);
        if (isD) vals.push_back(8'($urandom));
        else if ($urandom_range(3) == 0) vals.push_back(8'h80 | 8'($urandom_range(127)));
        else vals.push_back(8'($urandom_range(9)));
      end
      expand(kinds, vals, exp);
      rxQ.delete();
      fork
        begin foreach (kinds[i]) send_item(kinds[i], vals[i]); end
        do_read(exp.size(), 0, cnt, err);
      join
      cmp_q("R5 random expansion", exp);
      check("R11 random count", cnt == exp.size() && !err, cnt, exp.size());
    end
    randReady = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule